// File: doc/BRIEF.md
# Context Bank Allocator with Collision Trap

This block manages context switches for a small processor core that has no stack. Saving registers, flags and program counter to memory costs cycles. Instead, the block picks which bank of a shared register RAM is live. The live bank index is placed above the register index, so switching context is just a change of that index. No data moves.

Subroutine calls claim banks from the bottom of the RAM, one bank per call, and returns release them. Interrupt entry claims a bank from the top and moves the interrupt-side pointer down. Interrupts do not nest: an entry request that arrives while an interrupt bank is already live is dropped. Calls made inside an interrupt routine still come from the bottom region. When the routine's call depth is unwound, the interrupt bank is live again. A return from interrupt goes back to the newest call-side bank.

A request that would make the two pointers land on the same bank is refused. It also raises a trap flag, which stays set until reset. The RAM is modelled as a plain array in the block. The last register of each bank holds the saved program counter, and that value is brought out directly.

Top module: `ctx_bank_alloc`

## Requirements
- R1: After reset, bank_base is 0, in_irq is 0 and trap is 0.
- R2: A call request moves bank_base to the current call-side bank plus one on the next clock.
- R3: A return request moves the call-side bank down by one. It is ignored when the call-side bank is 0. It is also ignored while an interrupt is live and no call has been made inside that interrupt.
- R4: An interrupt-entry request with no interrupt live makes bank_base equal to NUM_BANKS-1 (15 by default) and sets in_irq on the next clock.
- R5: An interrupt-entry request while in_irq is 1 is ignored: bank_base, in_irq and trap keep their values.
- R6: A return-from-interrupt request while in_irq is 1 clears in_irq and restores bank_base to the newest call-side bank on the next clock. While in_irq is 0 the request is ignored.
- R7: The interrupt pointer rests at bank 15 and drops to 14 while an interrupt is live. A call or interrupt entry is refused and raises trap when the call-side bank plus one equals the interrupt pointer. With no interrupt live, calls stop at bank 14. Inside an interrupt they stop at bank 13. Interrupt entry is refused when the call-side bank is 14.
- R8: Once set, trap stays 1 until reset. Other requests are still served.
- R9: A register-file access uses the RAM address {bank_base, register index}, with the 3-bit index in the low bits. A write in one bank does not change the same register in another bank. rf_rdata shows the addressed register of the live bank without delay.
- R10: pc_value always shows register 7 of the live bank.
- R11: After a call made inside an interrupt routine returns, bank_base shows the interrupt bank again.
- R12: At most one of the four request inputs is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Subroutine call pulse |
| ret_req | input | 1 | Subroutine return pulse |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_return | input | 1 | Return-from-interrupt pulse |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 3 | Register index to write |
| rf_wdata | input | 8 | Write data |
| rf_raddr | input | 3 | Register index to read |
| rf_rdata | output | 8 | Read data from the live bank |
| pc_value | output | 8 | Register 7 of the live bank |
| bank_base | output | 4 | Live bank index, the upper RAM address bits |
| in_irq | output | 1 | An interrupt bank is live |
| trap | output | 1 | Sticky pointer-collision trap |

## Verification
The bench fills every call-side bank up to the collision limit and tags each bank's registers. It then unwinds the stack and checks that each tagged value is still there. A design with the wrong address concatenation, or with registers that alias across banks, reads back the wrong tags. The limit is tested three ways: with no interrupt live, inside an interrupt, and on interrupt entry itself. An off-by-one in the collision test would either refuse a legal bank or hand out the bank the other side owns. Nested entry, a return at bank 0, a return at the interrupt's entry depth, and a stray return-from-interrupt are all driven. A design that acts on any of them moves bank_base to the wrong place. A long run of mixed requests is then checked cycle by cycle against an arithmetic model.

// File: rtl/ctx_bank_alloc.sv
module ctx_bank_alloc #(
  parameter int NUM_BANKS = 16,
  parameter int REGS      = 8,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          call_req,
  input  logic                          ret_req,
  input  logic                          irq_enter,
  input  logic                          irq_return,
  input  logic                          rf_we,
  input  logic [$clog2(REGS)-1:0]       rf_waddr,
  input  logic [DATA_W-1:0]             rf_wdata,
  input  logic [$clog2(REGS)-1:0]       rf_raddr,
  output logic [DATA_W-1:0]             rf_rdata,
  output logic [DATA_W-1:0]             pc_value,
  output logic [$clog2(NUM_BANKS)-1:0]  bank_base,
  output logic                          in_irq,
  output logic                          trap
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int REG_W  = $clog2(REGS);
  localparam int WORDS  = NUM_BANKS * REGS;
  localparam logic [BANK_W-1:0] TOP     = BANK_W'(NUM_BANKS - 1);
  localparam logic [REG_W-1:0]  PC_SLOT = REG_W'(REGS - 1);

  logic [BANK_W-1:0] call_ptr, irq_ptr, irq_base;
  logic              trap_q;
  logic [DATA_W-1:0] rf_mem [WORDS];

  wire irq_act = (irq_ptr != TOP);
  wire at_isr  = irq_act && (call_ptr == irq_base);
  wire meet    = (BANK_W'(call_ptr + 1'b1) == irq_ptr);

  wire do_call = call_req && !meet;
  wire do_ret  = ret_req && (call_ptr != '0) && !at_isr;
  wire do_irq  = irq_enter && !irq_act && !meet;
  wire do_iret = irq_return && irq_act;
  wire refuse  = (call_req || (irq_enter && !irq_act)) && meet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_ptr <= '0;
      irq_ptr  <= TOP;
      irq_base <= '0;
      trap_q   <= 1'b0;
    end else begin
      if (do_call)     call_ptr <= call_ptr + 1'b1;
      else if (do_ret) call_ptr <= call_ptr - 1'b1;
      if (do_irq) begin
        irq_ptr  <= irq_ptr - 1'b1;
        irq_base <= call_ptr;
      end else if (do_iret) begin
        irq_ptr  <= TOP;
      end
      if (refuse) trap_q <= 1'b1;
    end
  end

  assign bank_base = at_isr ? BANK_W'(irq_ptr + 1'b1) : call_ptr;
  assign in_irq    = irq_act;
  assign trap      = trap_q;

  always_ff @(posedge clk) begin
    if (rf_we) rf_mem[{bank_base, rf_waddr}] <= rf_wdata;
  end

  assign rf_rdata = rf_mem[{bank_base, rf_raddr}];
  assign pc_value = rf_mem[{bank_base, PC_SLOT}];

  // R12
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({call_req, ret_req, irq_enter, irq_return}) <= 1);

  // R7
  ptr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_ptr != irq_ptr);

  // R7
  collide_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && meet) |=> (trap && $stable(call_ptr)));

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> trap);

  // R2
  call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !meet) |=> (bank_base == BANK_W'($past(call_ptr) + 1'b1)));

  // R5
  nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && in_irq) |=> ($stable(bank_base) && in_irq));

  // R6
  iret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && in_irq) |=> (!in_irq && bank_base == $past(call_ptr)));
endmodule

// File: tb/test_ctx_bank_alloc.sv
module test_ctx_bank_alloc;
  logic clk = 0, rst_n = 0;
  logic call_req = 0, ret_req = 0, irq_enter = 0, irq_return = 0;
  logic rf_we = 0;
  logic [2:0] rf_waddr = 0, rf_raddr = 0;
  logic [7:0] rf_wdata = 0, rf_rdata, pc_value;
  logic [3:0] bank_base;
  logic in_irq, trap;

  int checks = 0, failures = 0;
  int m_cp, m_base, m_irq, m_trap;

  always #2 clk = ~clk;

  ctx_bank_alloc i_ctx_bank_alloc (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .irq_enter(irq_enter), .irq_return(irq_return), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .pc_value(pc_value), .bank_base(bank_base),
    .in_irq(in_irq), .trap(trap));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_bank();
    return (m_irq != 0 && m_cp == m_base) ? 15 : m_cp;
  endfunction

  task automatic chk_state(input string tag);
    chk({tag, " bank"}, bank_base, exp_bank());
    chk({tag, " in_irq"}, in_irq, m_irq);
    chk({tag, " trap"}, trap, m_trap);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    m_cp = 0; m_base = 0; m_irq = 0; m_trap = 0;
  endtask

  // kind: 1 call, 2 ret, 3 irq entry, 4 irq return
  task automatic req(input int kind, input string tag);
    int ip;
    @(negedge clk);
    call_req = (kind == 1); ret_req = (kind == 2);
    irq_enter = (kind == 3); irq_return = (kind == 4);
    @(posedge clk); #1;
    call_req = 0; ret_req = 0; irq_enter = 0; irq_return = 0;
    ip = m_irq ? 14 : 15;
    case (kind)
      1: if (m_cp + 1 == ip) m_trap = 1; else m_cp++;
      2: if (m_cp != 0 && !(m_irq != 0 && m_cp == m_base)) m_cp--;
      3: if (m_irq == 0) begin
           if (m_cp + 1 == ip) m_trap = 1;
           else begin m_irq = 1; m_base = m_cp; end
         end
      4: m_irq = 0;
      default: ;
    endcase
    chk_state(tag);
  endtask

  task automatic wr(input int r, input int d);
    @(negedge clk);
    rf_we = 1; rf_waddr = 3'(r); rf_wdata = 8'(d);
    @(posedge clk); #1;
    rf_we = 0;
  endtask

  task automatic rd(input int r, input int exp, input string tag);
    @(negedge clk);
    rf_raddr = 3'(r);
    #1 chk(tag, rf_rdata, exp);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    #1 chk_state("R1 reset");

    // Fill every call bank, tagging reg3 and the PC slot
    for (int b = 0; b <= 14; b++) begin
      wr(3, 8'hA0 + b);
      wr(7, 8'h50 + b);
      #1 chk("R10 pc slot", pc_value, 8'h50 + b);
      if (b < 14) req(1, "R2 call");
    end
    req(1, "R7 call limit 14");
    chk("R7 bank held", bank_base, 14);
    for (int b = 14; b >= 0; b--) begin
      rd(3, 8'hA0 + b, "R9 bank tag");
      chk("R10 pc unwind", pc_value, 8'h50 + b);
      if (b > 0) req(2, "R3 ret");
    end
    req(2, "R3 ret at bank 0 ignored");
    req(4, "R6 iret without irq ignored");
    req(1, "R8 call after trap");

    // Interrupt phase
    do_reset();
    for (int i = 0; i < 5; i++) req(1, "R2 call");
    wr(3, 8'h33);
    req(3, "R4 irq entry");
    chk("R4 bank top", bank_base, 15);
    wr(3, 8'hEE);
    rd(3, 8'hEE, "R9 irq bank write");
    req(3, "R5 nested irq ignored");
    req(2, "R3 ret at isr depth ignored");
    for (int i = 0; i < 8; i++) req(1, "R2 call in isr");
    req(1, "R7 call limit 13 in isr");
    chk("R7 bank 13", bank_base, 13);
    for (int i = 0; i < 8; i++) req(2, "R11 unwind");
    chk("R11 back in irq bank", bank_base, 15);
    req(4, "R6 iret");
    chk("R6 bank restored", bank_base, 5);
    rd(3, 8'h33, "R9 bank5 untouched");
    req(4, "R6 second iret ignored");
    req(1, "R8 call after trap");

    // Interrupt entry collision
    do_reset();
    for (int i = 0; i < 14; i++) req(1, "R2 call");
    req(3, "R7 irq refused at 14");
    req(3, "R7 irq refused again");
    req(2, "R8 ret after trap");

    // Mixed request stream
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = 1 + int'($urandom % 4);
      if (k == 2 && ($urandom % 3) == 0) k = 1;
      req(k, "R2-mix");
      if (m_trap != 0 && ($urandom % 6) == 0) begin
        do_reset();
        #1 chk_state("R1 mix reset");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule